// File: doc/BRIEF.md
# Serial BCD to Excess-3 Code Converter

This block turns a decimal digit arriving one bit per clock into its Excess-3 code, also one bit per clock. The digit enters on `x` least significant bit first, and in the very same cycle the matching bit of the digit-plus-three code leaves on `z`. The block is a synchronous Mealy machine with seven working states held in three flip-flops. It walks one path through its graph per group of four bits and is back in its start state after every fourth bit, so digits may be streamed with no gap and no framing signal.

An optional output flop gives `z_q`, a copy of `z` one clock late that cannot glitch. The next-state and output logic comes in two forms, chosen by parameter: a decoded transition table, or flattened sum-of-products equations. Both forms give the same behaviour. The active-low reset clears the machine at once. Its release passes through a short synchronizer, so the machine starts counting bits only on a clean edge.

Top module: `bcd_xs3_serial`

## Requirements
- R1: While `rst_n` is low the machine sits in its start state: `z` equals the inverse of `x` (0 gives 1, 1 gives 0), and `z_q` is 0.
- R2: For every digit 0 to 9 sent LSB first on `x`, the four `z` bits seen in the same cycles as the input bits are, LSB first, the 4-bit value digit + 3.
- R3: After the fourth bit of a digit the machine is back in its start state, so any stream of digits sent back to back converts digit by digit with no idle cycle.
- R4: The all-zero digit yields the `z` sequence 1,1,0,0 (code 0011), and digit 7 (bits 1,1,1,0) yields 0,1,0,1 (code 1010).
- R5: Codes 10 to 15, which are not BCD, yield (code + 3) modulo 16 on `z`. For 13, 14 and 15 the fourth output bit is 0. The digit that follows any of them converts correctly.
- R6: With the output register enabled, `z_q` after each rising edge equals the `z` value present just before that edge, and it is 0 while the machine is held in reset.
- R7: After `rst_n` rises, the machine stays in its start state through the first SYNC_STAGES rising edges (2 by default). Only the next edge takes a bit.
- R8: Pulling `rst_n` low in the middle of a digit returns the machine to its start state at once, without a clock edge. `z` then reads the start-state value and `z_q` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `x` is sampled on the rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| x | input | 1 | Serial BCD digit bit, least significant bit first |
| z | output | 1 | Serial Excess-3 bit for the current input bit (Mealy, same cycle) |
| z_q | output | 1 | `z` delayed by one clock (0 when the output register is disabled) |

## Verification
Every valid digit is sent alone and then in long random back-to-back streams. Together these separate a wrong bit order or a wrong per-state output from a failure to return to the start state at a digit boundary. The two fixed sequences for 0 and 7 pin down the two extreme paths through the graph. The six non-BCD codes, each followed by a valid digit, expose any error in the recovery edges. A reset pulled mid-digit, and the edges right after reset is released, show whether reset is asynchronous and whether the release really waits on the synchronizer.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

   localparam int STATE_W    = 3;
   localparam int DIGIT_BITS = 4;
   localparam int PHASE_W    = $clog2(DIGIT_BITS);

   // State encoding: bit 0 flips on every legal step, and bit 1 alone
   // with the input sets the output bit.
   typedef enum logic [STATE_W-1:0] {
      ST_START  = 3'b000,  // awaiting bit 0
      ST_LO0    = 3'b001,  // bit 0 was 0
      ST_HI0    = 3'b011,  // bit 0 was 1
      ST_MID_C  = 3'b110,  // two bits taken, no carry pending
      ST_MID_K  = 3'b100,  // two bits taken, carry pending
      ST_END_C  = 3'b111,  // three bits taken, pass-through
      ST_END_K  = 3'b101,  // three bits taken, carry pending
      ST_SPARE  = 3'b010   // never entered; forced home
   } state_t;

endpackage

// File: rtl/bxs_rst_sync.sv
module bxs_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bxs_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_q = chain[STAGES-1];

endmodule

// File: rtl/bxs_step.sv
module bxs_step
   import bxs_pkg::*;
#(
   parameter int USE_EQN = 0
) (
   input  state_t cur,
   input  logic   x,
   output state_t nxt,
   output logic   z
);

   generate
      if (USE_EQN != 0 && USE_EQN != 1) begin : g_bad_style
         $error("bxs_step: USE_EQN must be 0 or 1");
      end

      if (USE_EQN == 1) begin : g_eqn
         logic q2, q1, q0, spare;
         logic [STATE_W-1:0] nbits;
         assign q2    = cur[2];
         assign q1    = cur[1];
         assign q0    = cur[0];
         assign spare = ~q2 & q1 & ~q0;

         assign nbits[2] = q2 ^ q0;
         assign nbits[1] = (~q2 & ~q1 & ~q0 &  x)
                         | (~q2 & ~q1 &  q0 & ~x)
                         | ( q2 & ~q1 & ~q0 & ~x)
                         | ( q2 &  q1 & ~q0);
         assign nbits[0] = ~q0 & (q2 | ~q1);

         assign nxt = state_t'(nbits);
         assign z   = (x ~^ q1) & ~spare;
      end else begin : g_tbl
         always_comb begin
            nxt = ST_START;
            z   = 1'b0;
            case (cur)
               ST_START: begin nxt = x ? ST_HI0   : ST_LO0;   z = ~x; end
               ST_LO0:   begin nxt = x ? ST_MID_K : ST_MID_C; z = ~x; end
               ST_HI0:   begin nxt = ST_MID_K;                z =  x; end
               ST_MID_C: begin nxt = ST_END_C;                z =  x; end
               ST_MID_K: begin nxt = x ? ST_END_K : ST_END_C; z = ~x; end
               ST_END_C: begin nxt = ST_START;                z =  x; end
               ST_END_K: begin nxt = ST_START;                z = ~x; end
               default:  begin nxt = ST_START;                z = 1'b0; end
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/bxs_zreg.sv
module bxs_zreg #(
   parameter int ENABLE = 1
) (
   input  logic clk,
   input  logic rst_q,
   input  logic z,
   output logic z_q
);

   generate
      if (ENABLE != 0 && ENABLE != 1) begin : g_bad_enable
         $error("bxs_zreg: ENABLE must be 0 or 1");
      end

      if (ENABLE == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_q) begin
            if (!rst_q) z_q <= 1'b0;
            else        z_q <= z;
         end

         AST_ZQ_DELAY: assert property (@(posedge clk) disable iff (!rst_q)
            rst_q |=> (z_q == $past(z)))
            else $error("z_q is not z delayed by one clock"); // R6
      end else begin : g_none
         assign z_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bcd_xs3_serial.sv
module bcd_xs3_serial #(
   parameter int REG_OUT     = 1,
   parameter int USE_EQN     = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic x,
   output logic z,
   output logic z_q
);
   import bxs_pkg::*;

   logic   rst_q;
   state_t state;
   state_t state_nxt;

   bxs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .rst_q (rst_q)
   );

   bxs_step #(.USE_EQN(USE_EQN)) u_step (
      .cur (state),
      .x   (x),
      .nxt (state_nxt),
      .z   (z)
   );

   always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) state <= ST_START;
      else        state <= state_nxt;
   end

   bxs_zreg #(.ENABLE(REG_OUT)) u_zreg (
      .clk   (clk),
      .rst_q (rst_q),
      .z     (z),
      .z_q   (z_q)
   );

   // Checker-only bit position within the current digit.
   logic [PHASE_W-1:0] phase;
   always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) phase <= '0;
      else        phase <= phase + 1'b1;
   end

   AST_DIGIT_HOME: assert property (@(posedge clk) disable iff (!rst_q)
      (phase == '0) |-> (state == ST_START))
      else $error("not in start state at digit boundary"); // R3

   AST_NO_SPARE: assert property (@(posedge clk) disable iff (!rst_q)
      state != ST_SPARE)
      else $error("spare state entered"); // R3

   AST_Q0_FLIPS: assert property (@(posedge clk) disable iff (!rst_q)
      (state != ST_SPARE) |=> (state[0] != $past(state[0])))
      else $error("state bit 0 did not flip"); // R2

   AST_HOLD_UNTIL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_q |=> (state == ST_START))
      else $error("machine moved before reset release completed"); // R7

endmodule

// File: tb/bcd_xs3_serial_test.sv
`timescale 1ns/1ps
module bcd_xs3_serial_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic x = 1'b0;
   logic z, z_q;
   int   total = 0;
   int   failed = 0;
   bit   done = 0;

   always #4 clk = ~clk;

   bcd_xs3_serial uut (
      .clk   (clk),
      .rst_n (rst_n),
      .x     (x),
      .z     (z),
      .z_q   (z_q)
   );

   function automatic logic [3:0] xs3_of(input logic [3:0] d);
      return 4'(d + 4'd3);
   endfunction

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_digit(input logic [3:0] d, input string tag);
      logic [3:0] got;
      logic       prev;
      logic       zq_ok;
      zq_ok = 1'b1;
      got   = '0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         x = d[i];
         #1;
         got[i] = z;
         prev   = z;
         @(posedge clk);
         #1;
         if (z_q !== prev) zq_ok = 1'b0;
      end
      check(tag, got, xs3_of(d));
      check("R6", {3'b0, zq_ok}, 4'd1);
   endtask

   task automatic release_reset();
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
   endtask

   initial begin
      void'($urandom(32'h5eed_0b3d));
      // R1: held in reset
      repeat (3) @(negedge clk);
      x = 1'b0; #1;
      check("R1", {3'b0, z}, 4'd1);
      x = 1'b1; #1;
      check("R1", {3'b0, z}, 4'd0);
      check("R1", {3'b0, z_q}, 4'd0);

      // R7: x held at 1 across release; start state keeps z at 0
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R7", {3'b0, z}, 4'd0);
      @(posedge clk); #1;
      check("R7", {3'b0, z}, 4'd0);

      // R4: fixed sequences
      send_digit(4'd0, "R4");
      send_digit(4'd7, "R4");

      // R2: every valid digit
      for (int d = 0; d < 10; d++) send_digit(4'(d), "R2");

      // R5: non-BCD codes, each followed by a valid digit
      for (int d = 10; d < 16; d++) begin
         send_digit(4'(d), "R5");
         send_digit(4'd5, "R5");
      end

      // R8: reset pulled mid-digit with the machine in a state where z differs
      @(negedge clk); x = 1'b1;
      @(posedge clk); #1;
      rst_n = 1'b0; #1;
      check("R8", {3'b0, z}, 4'd0);
      check("R8", {3'b0, z_q}, 4'd0);
      release_reset();
      send_digit(4'd9, "R8");

      // R3: random back-to-back streams
      for (int n = 0; n < 300; n++) begin
         logic [3:0] d;
         if (n % 5 == 4) d = 4'($urandom_range(15, 0));
         else            d = 4'($urandom_range(9, 0));
         send_digit(d, "R3");
      end

      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         failed++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

endmodule